// File: doc/BRIEF.md
# Loadable Boolean Constraint Propagation Engine

This block computes unit propagation for a formula in conjunctive normal form. Every clause slot holds two bit masks over a shared bus of variable values. One mask marks the variables that appear as plain literals and the other marks the variables that appear complemented. Clauses are written one literal per cycle, so the wiring between clauses and variables is data and no circuit is built for each problem.

A host applies a partial assignment and pulses `start`. On every cycle each clause evaluator checks whether it has exactly one literal that is not yet false, while none of its literals is true. If so, it drives an implication for that literal. A binary fan-in tree does this detection, so its logic grows linearly with the clause width. The variable evaluators OR the implications from all clauses into their 2-bit values. Repeating this cycle after cycle builds up the transitive implications.

The run ends with a one-cycle `done` pulse in either of two cases: the next values equal the current ones, or some variable has just become contradictory. After that the host reads the implied values, the contradiction flag and the falsified-clause flag.

Top module: `sat_bcp_engine`

## Requirements
- R1: After reset, `busy`, `done`, `contra` and `clash` are 0 and every variable code in `values` is 00. The clause masks are cleared.
- R2: A `start` pulse while idle replaces all variable codes with `assign_in` and sets `busy` on the next cycle, which discards the implications of any earlier run. Variable v occupies bits [2v+1:2v], and the codes are 00 free, 01 false, 10 true, 11 contradiction.
- R3: When a clause has no true literal and exactly one literal that is not false, it implies that literal. A plain literal drives its variable to 10 and a complemented literal drives it to 01. A plain literal is not false when its variable is 00 or 10, and a complemented literal is not false when its variable is 00 or 01.
- R4: All clauses are evaluated in parallel once per busy cycle. `done` is raised for one cycle after the first busy cycle in which no variable changes, so a run that needs k propagation steps ends after k+1 busy cycles.
- R5: A variable that receives both polarities, or already holds 11, ends as 11. `contra` is then 1, and the run stops with `done` after that same busy cycle.
- R6: A variable that holds a value, whether from the host or from an implication, keeps that value. It can only change to 11.
- R7: `clash` is 1 exactly when some clause holds at least one literal and none of its literals is not false.
- R8: A clause slot whose masks are all zero never implies a value and never reports a clash.
- R9: When idle, a write with `ld_en` adds one literal to clause `ld_clause`: variable `ld_var`, complemented if `ld_neg` is 1. With `ld_first` set, that clause's masks are cleared before the literal is added.
- R10: Literal writes are ignored while `busy` is 1.
- R11: `done` is a single-cycle pulse and is followed by `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one literal |
| ld_first | input | 1 | Clear the clause masks before adding the literal |
| ld_clause | input | $clog2(NCLAUSES) | Clause slot written |
| ld_var | input | $clog2(NVARS) | Variable of the literal |
| ld_neg | input | 1 | 1 for a complemented literal |
| start | input | 1 | Latch the assignment and begin propagation |
| assign_in | input | 2*NVARS | Partial assignment, 2 bits per variable |
| busy | output | 1 | Propagation running |
| done | output | 1 | One-cycle end-of-run pulse |
| values | output | 2*NVARS | Current variable codes |
| contra | output | 1 | Some variable is 11 |
| clash | output | 1 | Some loaded clause is entirely false |

## Verification
Before any clause is loaded, a few runs show that empty slots leave the assignment untouched and take exactly one cycle. A small formula with A and C set to true drives B both ways, which separates a contradiction that stops the run from an ordinary fixed point. Then a five-clause chain formula over four variables is swept through all 81 free/false/true assignments. For each assignment, a model in the bench predicts the final codes, both flags and the exact number of busy cycles, so errors in chain length, polarity, fixed-point detection and retention of host values show up. Further runs cover an assignment that is already contradictory, a literal write issued in mid-run, and the reloading of a clause slot.

// File: rtl/sat_bcp_pkg.sv
package sat_bcp_pkg;

  typedef logic [1:0] vcode_t;

  localparam vcode_t V_FREE   = 2'b00;
  localparam vcode_t V_FALSE  = 2'b01;
  localparam vcode_t V_TRUE   = 2'b10;
  localparam vcode_t V_CONTRA = 2'b11;

  // some literal of this variable in the clause can still become true
  function automatic logic lit_open(input logic pos, input logic neg, input vcode_t v);
    return (pos & ~v[0]) | (neg & ~v[1]);
  endfunction

  // some literal of this variable in the clause is already true
  function automatic logic lit_true(input logic pos, input logic neg, input vcode_t v);
    return (pos & v[1]) | (neg & v[0]);
  endfunction

  function automatic logic is_contra(input vcode_t v);
    return v[1] & v[0];
  endfunction

  // value after merging implications
  function automatic vcode_t merge_code(input vcode_t cur, input logic imp_t, input logic imp_f);
    return cur | {imp_t, imp_f};
  endfunction

endpackage

// File: rtl/sat_one_active.sv
module sat_one_active #(
  parameter int N = 4
) (
  input  logic [N-1:0] din,
  output logic         any,
  output logic         one
);
  localparam int LV = (N > 1) ? $clog2(N) : 0;
  localparam int P  = 1 << LV;

  // heap-ordered tree: node 1 is the root, leaves are P..2P-1
  logic a_n [1:2*P-1];
  logic m_n [1:2*P-1];

  genvar j;
  generate
    for (j = 0; j < P; j++) begin : g_leaf
      if (j < N) begin : g_real
        assign a_n[P+j] = din[j];
      end else begin : g_pad
        assign a_n[P+j] = 1'b0;
      end
      assign m_n[P+j] = 1'b0;
    end
    for (j = 1; j < P; j++) begin : g_node
      assign a_n[j] = a_n[2*j] | a_n[2*j+1];
      assign m_n[j] = m_n[2*j] | m_n[2*j+1] | (a_n[2*j] & a_n[2*j+1]);
    end
  endgenerate

  assign any = a_n[1];
  assign one = a_n[1] & ~m_n[1];
endmodule

// File: rtl/sat_clause_eval.sv
module sat_clause_eval
  import sat_bcp_pkg::*;
#(
  parameter int NVARS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NVARS-1:0]   pos_m,
  input  logic [NVARS-1:0]   neg_m,
  input  logic [2*NVARS-1:0] vals,
  output logic [NVARS-1:0]   imp_t,
  output logic [NVARS-1:0]   imp_f,
  output logic               conflict
);
  logic [NVARS-1:0] open_v;
  logic [NVARS-1:0] true_v;
  logic             any_open;
  logic             one_open;
  logic             satisfied;
  logic             present;
  logic             unit;

  genvar v;
  generate
    for (v = 0; v < NVARS; v++) begin : g_lit
      assign open_v[v] = lit_open(pos_m[v], neg_m[v], vals[2*v +: 2]);
      assign true_v[v] = lit_true(pos_m[v], neg_m[v], vals[2*v +: 2]);
    end
  endgenerate

  sat_one_active #(.N(NVARS)) u_tree (
    .din (open_v),
    .any (any_open),
    .one (one_open)
  );

  assign satisfied = |true_v;
  assign present   = |(pos_m | neg_m);
  assign unit      = one_open & ~satisfied;
  assign imp_t     = unit ? (pos_m & open_v) : '0;
  assign imp_f     = unit ? (neg_m & open_v) : '0;
  assign conflict  = present & ~any_open;

  // R8: an empty slot is inert
  a_r8_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !present |-> (imp_t == '0 && imp_f == '0 && !conflict));

  // R3: at most one variable is implied by a clause
  a_r3_single_implication: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(imp_t | imp_f));

  // R3: the tree flags exactly one open literal
  a_r3_tree_exact: assert property (@(posedge clk) disable iff (!rst_n)
    one_open |-> ($countones(open_v) == 1));

  // R7: a falsified clause implies nothing
  a_r7_conflict_silent: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> ((imp_t | imp_f) == '0));
endmodule

// File: rtl/sat_var_eval.sv
module sat_var_eval
  import sat_bcp_pkg::*;
#(
  parameter int NCLAUSES = 8
) (
  input  vcode_t              cur,
  input  logic [NCLAUSES-1:0] imp_t,
  input  logic [NCLAUSES-1:0] imp_f,
  output vcode_t              nxt
);
  assign nxt = merge_code(cur, |imp_t, |imp_f);
endmodule

// File: rtl/sat_bcp_engine.sv
module sat_bcp_engine
  import sat_bcp_pkg::*;
#(
  parameter  int NVARS    = 4,
  parameter  int NCLAUSES = 8,
  localparam int VW = (NVARS > 1) ? $clog2(NVARS) : 1,
  localparam int CW = (NCLAUSES > 1) ? $clog2(NCLAUSES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic               ld_first,
  input  logic [CW-1:0]      ld_clause,
  input  logic [VW-1:0]      ld_var,
  input  logic               ld_neg,
  input  logic               start,
  input  logic [2*NVARS-1:0] assign_in,
  output logic               busy,
  output logic               done,
  output logic [2*NVARS-1:0] values,
  output logic               contra,
  output logic               clash
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t state_q;
  logic   done_q;

  logic [NCLAUSES-1:0][NVARS-1:0] pos_q, neg_q;
  logic [NCLAUSES-1:0][NVARS-1:0] imp_t, imp_f;
  logic [NCLAUSES-1:0]            cl_conflict;
  logic [2*NVARS-1:0]             vals_q, vals_nxt;
  logic [NVARS-1:0]               cur_contra, nxt_contra_v;

  // named internal events
  logic             running;
  logic             nxt_contra;
  logic             fixpoint;
  logic             stop_now;
  logic             load_fire;
  logic [NVARS-1:0] ld_onehot;
  logic [NVARS-1:0] ld_pos_new, ld_neg_new;

  genvar c, v;
  generate
    for (c = 0; c < NCLAUSES; c++) begin : g_clause
      sat_clause_eval #(.NVARS(NVARS)) u_cl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_m    (pos_q[c]),
        .neg_m    (neg_q[c]),
        .vals     (vals_q),
        .imp_t    (imp_t[c]),
        .imp_f    (imp_f[c]),
        .conflict (cl_conflict[c])
      );
    end

    for (v = 0; v < NVARS; v++) begin : g_var
      logic [NCLAUSES-1:0] col_t, col_f;
      for (c = 0; c < NCLAUSES; c++) begin : g_col
        assign col_t[c] = imp_t[c][v];
        assign col_f[c] = imp_f[c][v];
      end
      sat_var_eval #(.NCLAUSES(NCLAUSES)) u_var (
        .cur   (vals_q[2*v +: 2]),
        .imp_t (col_t),
        .imp_f (col_f),
        .nxt   (vals_nxt[2*v +: 2])
      );
      assign cur_contra[v]   = is_contra(vals_q[2*v +: 2]);
      assign nxt_contra_v[v] = is_contra(vals_nxt[2*v +: 2]);
    end
  endgenerate

  assign running    = (state_q == S_RUN);
  assign nxt_contra = |nxt_contra_v;
  assign fixpoint   = (vals_nxt == vals_q);
  assign stop_now   = running & (fixpoint | nxt_contra);
  assign load_fire  = ld_en & ~running
                    & (int'(ld_clause) < NCLAUSES) & (int'(ld_var) < NVARS);

  always_comb begin
    ld_onehot = '0;
    if (int'(ld_var) < NVARS) ld_onehot[ld_var] = 1'b1;
    ld_pos_new = (ld_first ? '0 : pos_q[ld_clause]) | (ld_neg ? '0 : ld_onehot);
    ld_neg_new = (ld_first ? '0 : neg_q[ld_clause]) | (ld_neg ? ld_onehot : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      vals_q  <= '0;
      pos_q   <= '0;
      neg_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_fire) begin
        pos_q[ld_clause] <= ld_pos_new;
        neg_q[ld_clause] <= ld_neg_new;
      end
      case (state_q)
        S_IDLE: begin
          if (start) begin
            vals_q  <= assign_in;
            state_q <= S_RUN;
          end
        end
        S_RUN: begin
          vals_q <= vals_nxt;
          if (stop_now) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy   = running;
  assign done   = done_q;
  assign values = vals_q;
  assign contra = |cur_contra;
  assign clash  = |cl_conflict;

  // R6: no value bit is ever lost during a run
  a_r6_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ((vals_q & $past(vals_q)) == $past(vals_q)));

  // R5: a fresh contradiction ends the run at once
  a_r5_contra_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (running && nxt_contra) |=> (!busy && done && contra));

  // R10: masks do not move while propagating
  a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($stable(pos_q) && $stable(neg_q)));

  // R11: done is a lone pulse with the engine idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R4: the run only ends when nothing changes or a contradiction appears
  a_r4_end_reason: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fixpoint && !nxt_contra) |=> busy);
endmodule

// File: tb/sat_bcp_engine_test.sv
module sat_bcp_engine_test;
  localparam int NV = 4;
  localparam int NC = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_en = 1'b0;
  logic              ld_first = 1'b0;
  logic [2:0]        ld_clause = '0;
  logic [1:0]        ld_var = '0;
  logic              ld_neg = 1'b0;
  logic              start = 1'b0;
  logic [2*NV-1:0]   assign_in = '0;
  logic              busy, done, contra, clash;
  logic [2*NV-1:0]   values;

  int checks = 0;
  int errors = 0;

  // bench-side copy of the loaded formula
  bit [NV-1:0] mp [NC];
  bit [NV-1:0] mn [NC];

  logic [2*NV-1:0] exp_vals;
  int              exp_iter;
  bit              exp_contra, exp_clash;
  int              act_iter;

  sat_bcp_engine #(.NVARS(NV), .NCLAUSES(NC)) uut (
    .clk, .rst_n, .ld_en, .ld_first, .ld_clause, .ld_var, .ld_neg,
    .start, .assign_in, .busy, .done, .values, .contra, .clash
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put_lit(input int c, input int v, input bit neg, input bit first);
    ld_en = 1'b1; ld_first = first; ld_clause = 3'(c); ld_var = 2'(v); ld_neg = neg;
    @(negedge clk);
    ld_en = 1'b0; ld_first = 1'b0;
    if (first) begin mp[c] = '0; mn[c] = '0; end
    if (neg) mn[c][v] = 1'b1; else mp[c][v] = 1'b1;
  endtask

  // literal: +(v+1) plain, -(v+1) complemented
  task automatic put_clause(input int c, input int l0, input int l1, input int l2, input int l3);
    int lits[4];
    lits = '{l0, l1, l2, l3};
    for (int i = 0; i < 4; i++) begin
      if (lits[i] > 0) put_lit(c, lits[i] - 1, 1'b0, i == 0);
      else if (lits[i] < 0) put_lit(c, -lits[i] - 1, 1'b1, i == 0);
    end
  endtask

  function automatic bit open_lit(input bit neg, input logic [1:0] x);
    return neg ? (x == 2'b00 || x == 2'b01) : (x == 2'b00 || x == 2'b10);
  endfunction

  task automatic model_run(input logic [2*NV-1:0] asg);
    logic [1:0] cur [NV];
    logic [1:0] nx [NV];
    bit chg, ctr;
    for (int v = 0; v < NV; v++) cur[v] = asg[2*v +: 2];
    exp_iter = 0;
    forever begin
      for (int v = 0; v < NV; v++) nx[v] = cur[v];
      for (int c = 0; c < NC; c++) begin
        int ntrue = 0, nopen = 0, last = 0;
        bit lneg = 0;
        for (int v = 0; v < NV; v++) begin
          if (mp[c][v]) begin
            if (cur[v] == 2'b10) ntrue++;
            if (open_lit(0, cur[v])) begin nopen++; last = v; lneg = 0; end
          end
          if (mn[c][v]) begin
            if (cur[v] == 2'b01) ntrue++;
            if (open_lit(1, cur[v])) begin nopen++; last = v; lneg = 1; end
          end
        end
        if (ntrue == 0 && nopen == 1) nx[last] = nx[last] | (lneg ? 2'b01 : 2'b10);
      end
      exp_iter++;
      chg = 0; ctr = 0;
      for (int v = 0; v < NV; v++) begin
        if (nx[v] != cur[v]) chg = 1;
        if (nx[v] == 2'b11) ctr = 1;
        cur[v] = nx[v];
      end
      if (!chg || ctr || exp_iter > 50) break;
    end
    exp_contra = 0;
    for (int v = 0; v < NV; v++) begin
      exp_vals[2*v +: 2] = cur[v];
      if (cur[v] == 2'b11) exp_contra = 1;
    end
    exp_clash = 0;
    for (int c = 0; c < NC; c++) begin
      int nopen = 0;
      for (int v = 0; v < NV; v++) begin
        if (mp[c][v] && open_lit(0, cur[v])) nopen++;
        if (mn[c][v] && open_lit(1, cur[v])) nopen++;
      end
      if ((mp[c] | mn[c]) != '0 && nopen == 0) exp_clash = 1;
    end
  endtask

  // start a run; optionally try a literal write while busy (R10)
  task automatic run(input logic [2*NV-1:0] asg, input bit inject);
    assign_in = asg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    if (inject) begin
      ld_en = 1'b1; ld_first = 1'b1; ld_clause = 3'd0; ld_var = 2'd3; ld_neg = 1'b1;
    end
    act_iter = 0;
    while (act_iter < 60) begin
      @(negedge clk);
      ld_en = 1'b0; ld_first = 1'b0;
      act_iter++;
      if (done) break;
    end
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 done single pulse", {done, busy}, 0);
  endtask

  function automatic logic [2*NV-1:0] mk(input int a, input int b, input int c, input int d);
    logic [2*NV-1:0] r;
    r = '0;
    r[1:0] = 2'(a); r[3:2] = 2'(b); r[5:4] = 2'(c); r[7:6] = 2'(d);
    return r;
  endfunction

  task automatic full_check(input logic [2*NV-1:0] asg, input string tag);
    model_run(asg);
    chk(values == exp_vals, {tag, " values"}, values, exp_vals);
    chk(act_iter == exp_iter, {tag, " R4 cycles"}, act_iter, exp_iter);
    chk(contra == exp_contra && clash == exp_clash, {tag, " R5/R7 flags"},
        {contra, clash}, {exp_contra, exp_clash});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin mp[c] = '0; mn[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && contra == 0 && clash == 0, "R1 flags", {busy, done, contra, clash}, 0);
    chk(values == '0, "R1 values", values, 0);

    // R8 empty slots: assignment unchanged, one cycle
    run(mk(2, 1, 0, 2), 0);
    chk(values == mk(2, 1, 0, 2), "R8 empty values", values, mk(2, 1, 0, 2));
    chk(act_iter == 1 && clash == 0, "R8 empty cycles/clash", {act_iter[7:0], clash}, {8'd1, 1'b0});
    after_done();
    run('0, 0);
    chk(values == '0 && clash == 0, "R8 empty free", values, 0);

    // R9 load: (A+B+C)(A'+B')(B+C')(A'+B+C'); A,B,C = vars 0,1,2
    put_clause(0,  1,  2,  3, 0);
    put_clause(1, -1, -2,  0, 0);
    put_clause(2,  2, -3,  0, 0);
    put_clause(3, -1,  2, -3, 0);
    run(mk(2, 0, 2, 0), 0);
    chk(values[3:2] == 2'b11, "R5 B forced both ways", values[3:2], 2'b11);
    chk(contra == 1 && act_iter == 1, "R5 contra stops run", {contra, act_iter[7:0]}, {1'b1, 8'd1});
    full_check(mk(2, 0, 2, 0), "R9 scenario");
    after_done();
    // R2 a new start discards previous implications
    run('0, 0);
    full_check('0, "R2 restart free");
    run(mk(1, 0, 0, 0), 0);
    full_check(mk(1, 0, 0, 0), "R2 restart A false");

    // chain formula: (A'+B)(B'+C)(C'+D)(A+D')(A+B+C+D)
    put_clause(0, -1,  2,  0, 0);
    put_clause(1, -2,  3,  0, 0);
    put_clause(2, -3,  4,  0, 0);
    put_clause(3,  1, -4,  0, 0);
    put_clause(4,  1,  2,  3, 4);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++) begin
            logic [2*NV-1:0] asg;
            asg = mk(a, b, c, d);
            run(asg, 0);
            full_check(asg, "R3 sweep");
            // R6 host values retained (or turned to 11)
            chk((values & asg) == asg, "R6 host kept", values, asg);
          end

    // R10 literal write during a multi-cycle run is dropped
    run(mk(2, 0, 0, 0), 1);
    full_check(mk(2, 0, 0, 0), "R10 run with write");
    chk(act_iter == 4, "R4 chain length", act_iter, 4);
    run(mk(2, 0, 0, 0), 0);
    full_check(mk(2, 0, 0, 0), "R10 masks untouched");
    after_done();

    // R5 host already contradictory
    run(mk(3, 0, 0, 0), 0);
    chk(contra == 1 && act_iter == 1, "R5 host contra", {contra, act_iter[7:0]}, {1'b1, 8'd1});

    // R9 reload a slot with ld_first
    put_clause(5, 2, 0, 0, 0);
    put_clause(5, -3, 0, 0, 0);
    put_clause(4, 1, 2, 3, 4);
    run(mk(0, 0, 0, 0), 0);
    full_check('0, "R9 reload");
    chk(values[5:4] == 2'b01, "R9 reload C false", values[5:4], 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule